// File: doc/BRIEF.md
# VPW Serial Frame Receiver

This block receives frames of a single-wire variable-pulse-width vehicle network at 10.4 kbit/s. It takes a bus level that has already been synchronised to the system clock, where 1 means the bus is driven active and 0 means passive. It also takes a one-cycle enable that marks each microsecond. The block measures the width of every active and passive pulse in those ticks. Pulses that are too short to count are absorbed as noise. The remaining widths are sorted into short bits, long bits, frame delimiters (start of frame, end of data), end of frame and inter-frame space.

Decoded bits are packed into bytes MSB first. Each byte is handed out as a one-cycle strobe with its data, and a marker flags the first byte of a message. A serial CRC-8 runs over every byte after the start-of-frame symbol. Status outputs report bus idle, CRC error, oversize message and malformed symbols. The status flags of a message stay readable until the next frame starts.

Top module: `vpw_frame_rx`

## Requirements
- R1: `idle_o` is 0 during reset. After reset it stays 0 until the bus has been passive for 300 consecutive ticks, and it then rises.
- R2: An excursion of the bus to the opposite level lasting fewer than 34 ticks never changes `idle_o`, delivers no byte and changes no flag.
- R3: While waiting for a frame, only an active pulse of 164 to 239 ticks starts a frame. Any other active pulse is ignored: it delivers no byte and leaves `crc_err_o`, `len_err_o` and `sym_err_o` unchanged.
- R4: The first bit follows the start-of-frame pulse and is passive; later bits alternate level. A passive pulse of 34..96 ticks is 0 and one of 97..163 ticks is 1. An active pulse of 34..96 ticks is 1 and one of 97..163 ticks is 0. Bits are packed MSB first.
- R5: Each completed byte appears for one clock with `rx_valid_o`=1 and the byte on `rx_data_o`. `rx_som_o` is 1 with the first byte of a message only.
- R6: End of data is a passive period reaching 164 ticks. At that point `crc_err_o` becomes 0 if the last received byte is the ones' complement of the CRC-8 (polynomial 0x1D, start value 0xFF, MSB first) of the preceding bytes, with the start-of-frame symbol excluded; otherwise it becomes 1.
- R7: A message holds at most 12 bytes, the CRC byte included. Bytes beyond the twelfth are not delivered and set `len_err_o` to 1. A 12-byte message leaves it 0.
- R8: Inside a frame, an active pulse of 164 ticks or more, or end of data reached with a partial byte, sets `sym_err_o` to 1 and abandons the frame. A new start of frame is then ignored until the bus has been passive for 300 ticks.
- R9: A noise excursion shorter than 34 ticks inside a pulse is folded into that pulse, so the pulse's full width decides the bit.
- R10: `idle_o` falls when an active level is accepted and stays 0 while a frame is on the bus. Every accepted start of frame clears all three error flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle enable, once per microsecond |
| bus_i | input | 1 | Synchronised bus level, 1 = active |
| rx_valid_o | output | 1 | Byte strobe |
| rx_data_o | output | 8 | Received byte |
| rx_som_o | output | 1 | First byte of a message |
| idle_o | output | 1 | Inter-frame space seen and no traffic |
| crc_err_o | output | 1 | 1 = CRC of last message wrong |
| len_err_o | output | 1 | 1 = last message longer than 12 bytes |
| sym_err_o | output | 1 | 1 = malformed symbol in last message |

## Verification
The bench targets the edges of the timing classes:
- a start of frame at 170 and 230 ticks;
- data bits at 50, 80, 110 and 150 ticks;
- a short glitch placed inside a long pulse;
- a stray 128-tick active pulse on an idle bus.

A receiver with the glitch filter wrong would split the glitched pulse into two short bits and corrupt the byte. One that started frames on any active pulse would deliver bytes from the stray pulse.

Two messages sit either side of the length limit, one of 12 bytes and one of 13 bytes. A wrong limit either drops the CRC byte of the legal message or delivers a thirteenth byte.

After a symbol error, a complete frame is sent after only 250 ticks of passive bus. A receiver that resynchronised too early would deliver that frame instead of ignoring it.

// File: rtl/vpw_rx_pkg.sv
// Package: shared types and CRC arithmetic for the VPW frame receiver.
// Assumes an MSB-first bit stream and the 8-bit generator 0x1D.
package vpw_rx_pkg;

    localparam int          BYTE_W    = 8;
    localparam logic [7:0]  CRC_POLY  = 8'h1D;
    localparam logic [7:0]  CRC_SEED  = 8'hFF;
    localparam logic [7:0]  CRC_RESID = 8'hC4;

    typedef enum logic [2:0] {
        PW_RUNT,
        PW_SHORT,
        PW_LONG,
        PW_DELIM,
        PW_OVER
    } pw_class_e;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_BODY,
        ST_TAIL,
        ST_RESYNC
    } rx_state_e;

    typedef struct packed {
        logic crc_bad;
        logic too_long;
        logic bad_sym;
    } rx_flags_t;

    // Advance the CRC register by one serial bit.
    function automatic logic [7:0] crc_shift(input logic [7:0] cur, input logic din);
        logic fb;
        fb = cur[7] ^ din;
        return {cur[6:0], 1'b0} ^ (fb ? CRC_POLY : 8'h00);
    endfunction

endpackage

// File: rtl/vpw_pulse_meter.sv
// Module: measures pulse widths on the synchronised bus in microsecond ticks.
// A change of level is accepted only after the bus has held the opposite
// level for NOISE_MIN ticks. Shorter excursions are added to the running
// pulse. It reports each finished pulse, the start of every accepted active
// level, and passive run lengths crossing the end-of-data, end-of-frame and
// inter-frame thresholds.
// Assumes bus_i is already synchronised to clk and tick_i is a single-cycle pulse.
module vpw_pulse_meter #(
    parameter int CNT_W     = 10,
    parameter int NOISE_MIN = 34,
    parameter int EOD_MIN   = 164,
    parameter int EOF_MIN   = 240,
    parameter int IFS_MIN   = 300
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             bus_i,
    output logic             pulse_vld_o,
    output logic             pulse_act_o,
    output logic [CNT_W-1:0] pulse_len_o,
    output logic             act_start_o,
    output logic             eod_hit_o,
    output logic             eof_hit_o,
    output logic             ifs_hit_o
);

    localparam int               CAND_W  = $clog2(NOISE_MIN + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             lvl_q, lvl_d;
    logic [CNT_W-1:0] run_q, run_d, grow;
    logic [CAND_W-1:0] cand_q, cand_d;
    logic [CNT_W:0]   sum;
    logic             pv_d, pact_d, ast_d, eod_d, eof_d, ifs_d;
    logic [CNT_W-1:0] plen_d;

    // Saturating run length after folding pending candidate ticks back in.
    always_comb begin
        sum  = {1'b0, run_q} + {{(CNT_W + 1 - CAND_W){1'b0}}, cand_q} + {{CNT_W{1'b0}}, 1'b1};
        grow = sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
    end

    // Next-state of the level filter and the event strobes.
    always_comb begin
        lvl_d  = lvl_q;
        run_d  = run_q;
        cand_d = cand_q;
        pv_d   = 1'b0;
        pact_d = 1'b0;
        plen_d = run_q;
        ast_d  = 1'b0;
        eod_d  = 1'b0;
        eof_d  = 1'b0;
        ifs_d  = 1'b0;
        if (tick_i) begin
            if (bus_i == lvl_q) begin
                run_d  = grow;
                cand_d = '0;
                if (!lvl_q) begin
                    eod_d = (int'(run_q) < EOD_MIN) && (int'(grow) >= EOD_MIN);
                    eof_d = (int'(run_q) < EOF_MIN) && (int'(grow) >= EOF_MIN);
                    ifs_d = (int'(run_q) < IFS_MIN) && (int'(grow) >= IFS_MIN);
                end
            end else if (int'(cand_q) + 1 >= NOISE_MIN) begin
                pv_d   = 1'b1;
                pact_d = lvl_q;
                lvl_d  = !lvl_q;
                run_d  = CNT_W'(NOISE_MIN);
                cand_d = '0;
                ast_d  = !lvl_q;
            end else begin
                cand_d = cand_q + 1'b1;
            end
        end
    end

    // State and registered event outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q       <= 1'b0;
            run_q       <= '0;
            cand_q      <= '0;
            pulse_vld_o <= 1'b0;
            pulse_act_o <= 1'b0;
            pulse_len_o <= '0;
            act_start_o <= 1'b0;
            eod_hit_o   <= 1'b0;
            eof_hit_o   <= 1'b0;
            ifs_hit_o   <= 1'b0;
        end else begin
            lvl_q       <= lvl_d;
            run_q       <= run_d;
            cand_q      <= cand_d;
            pulse_vld_o <= pv_d;
            pulse_act_o <= pact_d;
            pulse_len_o <= plen_d;
            act_start_o <= ast_d;
            eod_hit_o   <= eod_d;
            eof_hit_o   <= eof_d;
            ifs_hit_o   <= ifs_d;
        end
    end

    // R2
    edge_needs_opposite_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_vld_o |-> ($past(bus_i) != pulse_act_o));

    // R1
    ifs_on_passive_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ifs_hit_o |-> !$past(bus_i));

endmodule

// File: rtl/vpw_width_sorter.sv
// Module: sorts a measured pulse width into a symbol class.
// Purely combinational. Assumes ascending limits: NOISE_MIN <= SHORT_MAX < LONG_MAX < DELIM_MAX.
module vpw_width_sorter
    import vpw_rx_pkg::*;
#(
    parameter int CNT_W     = 10,
    parameter int NOISE_MIN = 34,
    parameter int SHORT_MAX = 96,
    parameter int LONG_MAX  = 163,
    parameter int DELIM_MAX = 239
) (
    input  logic [CNT_W-1:0] len_i,
    output pw_class_e        cls_o
);

    // Compare the width against the ascending class limits.
    always_comb begin
        if (int'(len_i) < NOISE_MIN)       cls_o = PW_RUNT;
        else if (int'(len_i) <= SHORT_MAX) cls_o = PW_SHORT;
        else if (int'(len_i) <= LONG_MAX)  cls_o = PW_LONG;
        else if (int'(len_i) <= DELIM_MAX) cls_o = PW_DELIM;
        else                               cls_o = PW_OVER;
    end

endmodule

// File: rtl/vpw_crc8_serial.sv
// Module: bit-serial CRC-8 register.
// It reloads its start value on seed_i and absorbs one bit per bit_vld_i.
// Assumes seed_i and bit_vld_i are never asserted together.
module vpw_crc8_serial
    import vpw_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       seed_i,
    input  logic       bit_vld_i,
    input  logic       bit_i,
    output logic [7:0] crc_o
);

    // Seed on frame start, then shift in each decoded bit.
    always_ff @(posedge clk) begin
        if (!rst_n)         crc_o <= CRC_SEED;
        else if (seed_i)    crc_o <= CRC_SEED;
        else if (bit_vld_i) crc_o <= crc_shift(crc_o, bit_i);
    end

    // R6
    seed_not_with_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seed_i |-> !bit_vld_i);

endmodule

// File: rtl/vpw_frame_rx.sv
// Module: VPW frame receiver top.
// It turns classified pulses into bytes, checks the CRC at end of data,
// caps the message length and keeps the idle and error flags.
// Assumes a filtered, synchronised bus (1 = active) and a 1 us tick enable.
module vpw_frame_rx
    import vpw_rx_pkg::*;
#(
    parameter int NOISE_MIN = 34,
    parameter int SHORT_MAX = 96,
    parameter int LONG_MAX  = 163,
    parameter int DELIM_MAX = 239,
    parameter int IFS_MIN   = 300,
    parameter int MAX_BYTES = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       bus_i,
    output logic       rx_valid_o,
    output logic [7:0] rx_data_o,
    output logic       rx_som_o,
    output logic       idle_o,
    output logic       crc_err_o,
    output logic       len_err_o,
    output logic       sym_err_o
);

    localparam int EOD_MIN = LONG_MAX + 1;
    localparam int EOF_MIN = DELIM_MAX + 1;
    localparam int CNT_W   = $clog2(IFS_MIN + 1) + 1;
    localparam int BC_W    = $clog2(MAX_BYTES + 1);
    localparam int BIT_W   = $clog2(BYTE_W);

    logic             pulse_vld, pulse_act, act_start, eod_hit, eof_hit, ifs_hit;
    logic [CNT_W-1:0] pulse_len;
    pw_class_e        cls;
    logic [7:0]       crc_val;

    rx_state_e         state_q, state_d;
    logic [BYTE_W-1:0] shreg_q, shreg_d;
    logic [BIT_W-1:0]  bitcnt_q, bitcnt_d;
    logic [BC_W-1:0]   bytecnt_q, bytecnt_d;
    logic              first_q, first_d;
    logic              idle_q, idle_d;
    rx_flags_t         flags_q, flags_d;
    logic              vld_q, vld_d, som_q, som_d;
    logic [BYTE_W-1:0] data_q, data_d;
    logic              bit_vld, bit_val, crc_seed;

    vpw_pulse_meter #(
        .CNT_W(CNT_W), .NOISE_MIN(NOISE_MIN), .EOD_MIN(EOD_MIN),
        .EOF_MIN(EOF_MIN), .IFS_MIN(IFS_MIN)
    ) u_meter (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .bus_i(bus_i),
        .pulse_vld_o(pulse_vld), .pulse_act_o(pulse_act), .pulse_len_o(pulse_len),
        .act_start_o(act_start), .eod_hit_o(eod_hit), .eof_hit_o(eof_hit),
        .ifs_hit_o(ifs_hit)
    );

    vpw_width_sorter #(
        .CNT_W(CNT_W), .NOISE_MIN(NOISE_MIN), .SHORT_MAX(SHORT_MAX),
        .LONG_MAX(LONG_MAX), .DELIM_MAX(DELIM_MAX)
    ) u_sorter (
        .len_i(pulse_len), .cls_o(cls)
    );

    vpw_crc8_serial u_crc (
        .clk(clk), .rst_n(rst_n), .seed_i(crc_seed), .bit_vld_i(bit_vld),
        .bit_i(bit_val), .crc_o(crc_val)
    );

    // Frame sequencing, bit packing and flag updates.
    always_comb begin
        state_d   = state_q;
        shreg_d   = shreg_q;
        bitcnt_d  = bitcnt_q;
        bytecnt_d = bytecnt_q;
        first_d   = first_q;
        flags_d   = flags_q;
        idle_d    = idle_q;
        vld_d     = 1'b0;
        som_d     = 1'b0;
        data_d    = data_q;
        bit_vld   = 1'b0;
        bit_val   = 1'b0;
        crc_seed  = 1'b0;

        if (act_start) idle_d = 1'b0;
        if (ifs_hit)   idle_d = 1'b1;

        unique case (state_q)
            ST_HUNT: begin
                if (pulse_vld && pulse_act && cls == PW_DELIM) begin
                    state_d   = ST_BODY;
                    crc_seed  = 1'b1;
                    bitcnt_d  = '0;
                    bytecnt_d = '0;
                    first_d   = 1'b1;
                    flags_d   = '0;
                end
            end
            ST_BODY: begin
                if (pulse_vld) begin
                    unique case (cls)
                        PW_SHORT: begin bit_vld = 1'b1; bit_val = pulse_act;  end
                        PW_LONG:  begin bit_vld = 1'b1; bit_val = !pulse_act; end
                        default: begin
                            flags_d.bad_sym = 1'b1;
                            state_d         = ST_RESYNC;
                        end
                    endcase
                end else if (eod_hit) begin
                    if (bitcnt_q != '0 || first_q) begin
                        flags_d.bad_sym = 1'b1;
                        state_d         = ST_RESYNC;
                    end else begin
                        flags_d.crc_bad = (crc_val != CRC_RESID);
                        state_d         = ST_TAIL;
                    end
                end
            end
            ST_TAIL: begin
                if (eof_hit) state_d = ST_HUNT;
            end
            ST_RESYNC: begin
                if (ifs_hit) state_d = ST_HUNT;
            end
            default: state_d = ST_HUNT;
        endcase

        if (bit_vld) begin
            shreg_d  = {shreg_q[BYTE_W-2:0], bit_val};
            bitcnt_d = bitcnt_q + 1'b1;
            if (bitcnt_q == BIT_W'(BYTE_W - 1)) begin
                if (int'(bytecnt_q) < MAX_BYTES) begin
                    vld_d     = 1'b1;
                    data_d    = {shreg_q[BYTE_W-2:0], bit_val};
                    som_d     = first_q;
                    first_d   = 1'b0;
                    bytecnt_d = bytecnt_q + 1'b1;
                end else begin
                    flags_d.too_long = 1'b1;
                end
            end
        end
    end

    // Register the sequencer state and the outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_HUNT;
            shreg_q   <= '0;
            bitcnt_q  <= '0;
            bytecnt_q <= '0;
            first_q   <= 1'b0;
            idle_q    <= 1'b0;
            flags_q   <= '0;
            vld_q     <= 1'b0;
            som_q     <= 1'b0;
            data_q    <= '0;
        end else begin
            state_q   <= state_d;
            shreg_q   <= shreg_d;
            bitcnt_q  <= bitcnt_d;
            bytecnt_q <= bytecnt_d;
            first_q   <= first_d;
            idle_q    <= idle_d;
            flags_q   <= flags_d;
            vld_q     <= vld_d;
            som_q     <= som_d;
            data_q    <= data_d;
        end
    end

    assign rx_valid_o = vld_q;
    assign rx_data_o  = data_q;
    assign rx_som_o   = som_q;
    assign idle_o     = idle_q;
    assign crc_err_o  = flags_q.crc_bad;
    assign len_err_o  = flags_q.too_long;
    assign sym_err_o  = flags_q.bad_sym;

    // R5
    som_only_with_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_som_o |-> rx_valid_o);

    // R10
    no_byte_while_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> !idle_o);

    // R1
    idle_rise_after_ifs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle_o) |-> $past(ifs_hit));

    // R7
    byte_count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(bytecnt_q) <= MAX_BYTES);

    // R6
    crc_flag_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crc_err_o) |-> $past(state_q == ST_BODY && eod_hit));

endmodule

// File: tb/vpw_frame_rx_bench.sv
module vpw_frame_rx_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       bus = 1'b0;
    logic       rx_valid, rx_som, idle, crc_err, len_err, sym_err;
    logic [7:0] rx_data;

    int checks = 0;
    int errors = 0;
    logic [7:0] tx_buf [0:15];
    logic [7:0] rx_buf [0:63];
    logic       rx_somb[0:63];
    int rx_cnt = 0;
    int rx_base = 0;

    always #5 clk = ~clk;
    always @(negedge clk) tick <= ~tick;

    vpw_frame_rx u_vpw_frame_rx (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .bus_i(bus),
        .rx_valid_o(rx_valid), .rx_data_o(rx_data), .rx_som_o(rx_som),
        .idle_o(idle), .crc_err_o(crc_err), .len_err_o(len_err), .sym_err_o(sym_err)
    );

    always @(negedge clk) begin
        if (rst_n && rx_valid && rx_cnt < 64) begin
            rx_buf[rx_cnt]  = rx_data;
            rx_somb[rx_cnt] = rx_som;
            rx_cnt          = rx_cnt + 1;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            while (!tick) @(posedge clk);
        end
        @(negedge clk);
    endtask

    task automatic pulse(input logic lvl, input int w, input bit glitch);
        bus = lvl;
        if (glitch) begin
            wait_ticks(w / 2);
            bus = !lvl;
            wait_ticks(8);
            bus = lvl;
            wait_ticks(w - w / 2 - 8);
        end else begin
            wait_ticks(w);
        end
    endtask

    function automatic logic [7:0] tx_crc(input int n);
        logic [7:0] c;
        logic fb;
        c = 8'hFF;
        for (int i = 0; i < n; i++)
            for (int b = 7; b >= 0; b--) begin
                fb = c[7] ^ tx_buf[i][b];
                c  = {c[6:0], 1'b0} ^ (fb ? 8'h1D : 8'h00);
            end
        return ~c;
    endfunction

    // Sends SOF, n data bytes plus a CRC byte (optionally corrupted), then a long passive gap.
    task automatic send_frame(input int n, input bit good, input int sof_w,
                              input int sh, input int lg, input bit glitch);
        logic lvl;
        int   w;
        bit   used;
        tx_buf[n] = good ? tx_crc(n) : (tx_crc(n) ^ 8'h01);
        used = 1'b0;
        pulse(1'b1, sof_w, 1'b0);
        check("R10 idle low in frame", int'(idle), 0);
        lvl = 1'b0;
        for (int i = 0; i <= n; i++)
            for (int b = 7; b >= 0; b--) begin
                if (lvl) w = tx_buf[i][b] ? sh : lg;
                else     w = tx_buf[i][b] ? lg : sh;
                pulse(lvl, w, glitch && !used && w >= 100);
                if (glitch && w >= 100) used = 1'b1;
                lvl = !lvl;
            end
        pulse(1'b0, 320, 1'b0);
    endtask

    task automatic expect_bytes(input string req, input int n);
        check({req, " byte count"}, rx_cnt - rx_base, n);
        for (int i = 0; i < n && rx_base + i < rx_cnt; i++) begin
            check({req, " byte value"}, int'(rx_buf[rx_base + i]), int'(tx_buf[i]));
            check("R5 start marker", int'(rx_somb[rx_base + i]), (i == 0) ? 1 : 0);
        end
    endtask

    task automatic t_reset;
        bus = 1'b0;
        rst_n = 1'b0;
        repeat (6) @(negedge clk);
        check("R1 idle in reset", int'(idle), 0);
        check("R1 valid in reset", int'(rx_valid), 0);
        check("R1 flags in reset", int'({crc_err, len_err, sym_err}), 0);
        rst_n = 1'b1;
        wait_ticks(290);
        check("R1 idle before IFS", int'(idle), 0);
        wait_ticks(20);
        check("R1 idle after IFS", int'(idle), 1);
    endtask

    task automatic t_noise;
        rx_base = rx_cnt;
        pulse(1'b1, 20, 1'b0);
        check("R2 idle during glitch", int'(idle), 1);
        pulse(1'b0, 60, 1'b0);
        check("R2 idle after glitch", int'(idle), 1);
        check("R2 no bytes", rx_cnt - rx_base, 0);
    endtask

    task automatic t_basic;
        rx_base = rx_cnt;
        tx_buf[0] = 8'h68; tx_buf[1] = 8'h6A; tx_buf[2] = 8'hF1;
        send_frame(3, 1'b1, 200, 64, 128, 1'b0);
        expect_bytes("R4", 4);
        check("R6 good crc", int'(crc_err), 0);
        check("R8 no sym err", int'(sym_err), 0);
        check("R10 idle after frame", int'(idle), 1);
    endtask

    task automatic t_glitch_tol;
        rx_base = rx_cnt;
        tx_buf[0] = 8'hA5; tx_buf[1] = 8'h3C;
        send_frame(2, 1'b1, 170, 50, 150, 1'b1);
        expect_bytes("R9", 3);
        check("R9 crc after glitch", int'(crc_err), 0);
    endtask

    task automatic t_bad_crc;
        rx_base = rx_cnt;
        tx_buf[0] = 8'h12; tx_buf[1] = 8'hE7; tx_buf[2] = 8'h00;
        send_frame(3, 1'b0, 230, 80, 110, 1'b0);
        expect_bytes("R6", 4);
        check("R6 crc error flagged", int'(crc_err), 1);
    endtask

    task automatic t_non_sof;
        rx_base = rx_cnt;
        pulse(1'b1, 128, 1'b0);
        pulse(1'b0, 320, 1'b0);
        pulse(1'b1, 260, 1'b0);
        pulse(1'b0, 320, 1'b0);
        check("R3 no bytes", rx_cnt - rx_base, 0);
        check("R3 crc flag kept", int'(crc_err), 1);
        check("R3 sym flag kept", int'(sym_err), 0);
        check("R3 idle back", int'(idle), 1);
    endtask

    task automatic t_length;
        rx_base = rx_cnt;
        for (int i = 0; i < 11; i++) tx_buf[i] = 8'(i * 37 + 5);
        send_frame(11, 1'b1, 200, 64, 128, 1'b0);
        expect_bytes("R7", 12);
        check("R7 twelve bytes ok", int'(len_err), 0);
        check("R10 flags cleared by SOF", int'(crc_err), 0);
        rx_base = rx_cnt;
        for (int i = 0; i < 12; i++) tx_buf[i] = 8'(i * 91 + 3);
        send_frame(12, 1'b1, 200, 64, 128, 1'b0);
        expect_bytes("R7", 12);
        check("R7 thirteen bytes flagged", int'(len_err), 1);
    endtask

    task automatic t_resync;
        rx_base = rx_cnt;
        pulse(1'b1, 200, 1'b0);
        pulse(1'b0, 64, 1'b0);
        pulse(1'b1, 250, 1'b0);
        pulse(1'b0, 250, 1'b0);
        check("R8 sym error", int'(sym_err), 1);
        tx_buf[0] = 8'h55; tx_buf[1] = 8'h81;
        send_frame(2, 1'b1, 200, 64, 128, 1'b0);
        check("R8 frame ignored before IFS", rx_cnt - rx_base, 0);
        check("R8 sym error held", int'(sym_err), 1);
        rx_base = rx_cnt;
        send_frame(2, 1'b1, 200, 64, 128, 1'b0);
        expect_bytes("R8", 3);
        check("R8 sym error cleared", int'(sym_err), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_noise();
        t_basic();
        t_glitch_tol();
        t_bad_crc();
        t_non_sof();
        t_length();
        t_resync();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule